// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic Unit with Status Flags

This block is the data-path core of a small 8-bit execution unit. It holds two
accumulators, called A and B, and a four-bit status register with the negative (N),
zero (Z), signed-overflow (V) and carry/borrow (C) flags. Each cycle in which
`op_valid` is high, the block takes one 4-bit operation code and one 8-bit operand.
The operand is either an immediate value or data already fetched from memory. On the
next rising clock edge the block updates the selected accumulator, the store-data
register and the flags. Instruction decode, operand fetch and the memory bus belong to
the surrounding pipeline.

There are six operation classes. Each has its own rule for the flags:

- **Load** writes the operand into an accumulator.
- **Store** presents an accumulator on `store_data`.
- **Add** and **subtract** write their result back and work for both signed and unsigned data.
- **Compare** subtracts without writing the result back.
- **Test** compares an accumulator with zero.

Loads and stores clear V and keep C. The arithmetic classes set all four flags.

The block has no multi-cycle sequencing. Every accepted operation completes in one
clock. The only state is the two accumulators, the store-data register and the flags.

Top module: `acc_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `acc_a`, `acc_b`, `store_data` and `flags` to zero. The bit order of `flags` is {N,Z,V,C}, with N at bit 3 and C at bit 0.
- R2: For every flag-setting operation, N equals bit 7 of the 8-bit result. Z is 1 exactly when all eight result bits are zero.
- R3: Load (opcode 0x0 = A, 0x1 = B) writes the operand into the selected accumulator. It sets N and Z from the operand, clears V and keeps C at its previous value.
- R4: Store (0x2 = A, 0x3 = B) copies the selected accumulator to `store_data`. It sets N and Z from that value, clears V, keeps C and leaves both accumulators unchanged.
- R5: Add (0x4 = A, 0x5 = B) writes X+M mod 256 to the selected accumulator. V = X7·M7·!R7 + !X7·!M7·R7 and C = X7·M7 + M7·!R7 + !R7·X7. For example, 0x7F + 0x01 gives 0x80 with flags 1010.
- R6: Subtract (0x6 = A, 0x7 = B) writes X−M mod 256 to the selected accumulator. V = X7·!M7·!R7 + !X7·M7·R7, and C is 1 when M > X unsigned. For example, 0x20 − 0x81 gives 0x9F with flags 1011.
- R7: Compare (0x8 = A, 0x9 = B) sets all four flags exactly as subtract would and leaves both accumulators unchanged.
- R8: Test (0xA = A, 0xB = B) sets the flags as subtracting zero from the selected accumulator would, ignoring the operand. On a value of 0x00 this gives flags 0100. The accumulators are unchanged.
- R9: While `op_valid` is low, the accumulators, `store_data` and `flags` keep their values whatever the opcode and operand are.
- R10: Opcodes 0xC to 0xF with `op_valid` high change no state.
- R11: Opcode bit 0 selects the accumulator (0 = A, 1 = B). An operation on one accumulator never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation code; bit 0 selects the accumulator |
| operand | input | 8 | Immediate or memory data |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| store_data | output | 8 | Value of the last stored accumulator |
| flags | output | 4 | Status flags {N,Z,V,C} |

## Verification
Every piece of state is visible at a port one clock after the operation that writes
it. A wrong accumulator value, a wrong flag or a write to the wrong register therefore
shows up on the next sample.

A carry flag that is lost or wrongly kept is hidden during loads and stores. It only
appears at the next load or store, which must keep C. For that reason the vector
sequence puts loads and stores directly after operations that set and clear the
carry.

Compare and test write back nothing, so an accumulator wrongly modified by one of them
is found through the accumulator ports on the same sample.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;

    localparam int DATA_W = 8;
    localparam int OPC_W  = 4;
    localparam int FLAG_W = 4;

    // flag bit positions inside the status word
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    typedef enum logic [2:0] {
        CLS_LOAD  = 3'd0,
        CLS_STORE = 3'd1,
        CLS_ADD   = 3'd2,
        CLS_SUB   = 3'd3,
        CLS_CMP   = 3'd4,
        CLS_TEST  = 3'd5,
        CLS_NONE  = 3'd7
    } op_class_e;

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
    import acc_flag_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic [OW-1:0] opcode,
    output op_class_e     op_class,
    output logic          acc_sel
);

    localparam int GRP_W = OW - 1;

    logic [GRP_W-1:0] group;

    assign group   = opcode[OW-1:1];
    assign acc_sel = opcode[0];

    always_comb begin
        unique case (group)
            GRP_W'(0): op_class = CLS_LOAD;
            GRP_W'(1): op_class = CLS_STORE;
            GRP_W'(2): op_class = CLS_ADD;
            GRP_W'(3): op_class = CLS_SUB;
            GRP_W'(4): op_class = CLS_CMP;
            GRP_W'(5): op_class = CLS_TEST;
            default:   op_class = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/acc_arith_core.sv
module acc_arith_core
    import acc_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_class_e         op_class,
    input  logic [W-1:0]      x_val,
    input  logic [W-1:0]      m_val,
    input  logic [FLAG_W-1:0] flags_q,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] flags_d,
    output logic              wr_acc,
    output logic              wr_store,
    output logic              wr_flags
);

    localparam int MSB = W - 1;

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic [W-1:0] m_sub;
    logic         add_v, add_c, sub_v, sub_c;

    // test uses zero as the subtrahend
    assign m_sub = (op_class == CLS_TEST) ? '0 : m_val;

    assign sum  = x_val + m_val;
    assign diff = x_val - m_sub;

    assign add_v = (x_val[MSB] & m_val[MSB] & ~sum[MSB])
                 | (~x_val[MSB] & ~m_val[MSB] & sum[MSB]);
    assign add_c = (x_val[MSB] & m_val[MSB]) | (m_val[MSB] & ~sum[MSB])
                 | (~sum[MSB] & x_val[MSB]);

    assign sub_v = (x_val[MSB] & ~m_sub[MSB] & ~diff[MSB])
                 | (~x_val[MSB] & m_sub[MSB] & diff[MSB]);
    assign sub_c = (m_sub > x_val);

    always_comb begin
        result   = '0;
        wr_acc   = 1'b0;
        wr_store = 1'b0;
        wr_flags = 1'b1;
        flags_d  = flags_q;
        unique case (op_class)
            CLS_LOAD: begin
                result = m_val;
                wr_acc = 1'b1;
                flags_d[FLG_V] = 1'b0;
            end
            CLS_STORE: begin
                result   = x_val;
                wr_store = 1'b1;
                flags_d[FLG_V] = 1'b0;
            end
            CLS_ADD: begin
                result = sum;
                wr_acc = 1'b1;
                flags_d[FLG_V] = add_v;
                flags_d[FLG_C] = add_c;
            end
            CLS_SUB: begin
                result = diff;
                wr_acc = 1'b1;
                flags_d[FLG_V] = sub_v;
                flags_d[FLG_C] = sub_c;
            end
            CLS_CMP, CLS_TEST: begin
                result = diff;
                flags_d[FLG_V] = sub_v;
                flags_d[FLG_C] = sub_c;
            end
            default: begin
                wr_flags = 1'b0;
            end
        endcase
        if (wr_flags) begin
            flags_d[FLG_N] = result[MSB];
            flags_d[FLG_Z] = (result == '0);
        end
    end

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
    import acc_flag_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int OW   = OPC_W,
    parameter int NACC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OW-1:0]     opcode,
    input  logic [W-1:0]      operand,
    output logic [W-1:0]      acc_a,
    output logic [W-1:0]      acc_b,
    output logic [W-1:0]      store_data,
    output logic [FLAG_W-1:0] flags
);

    localparam int SEL_W = (NACC > 1) ? $clog2(NACC) : 1;

    op_class_e         op_class;
    logic              acc_sel;
    logic [W-1:0]      acc_q [NACC];
    logic [W-1:0]      x_val;
    logic [W-1:0]      result;
    logic [FLAG_W-1:0] flags_q, flags_d;
    logic [W-1:0]      store_q;
    logic              wr_acc, wr_store, wr_flags;

    acc_op_decode #(.OW(OW)) u_dec (
        .opcode   (opcode),
        .op_class (op_class),
        .acc_sel  (acc_sel)
    );

    assign x_val = acc_q[SEL_W'(acc_sel)];

    acc_arith_core #(.W(W)) u_core (
        .op_class (op_class),
        .x_val    (x_val),
        .m_val    (operand),
        .flags_q  (flags_q),
        .result   (result),
        .flags_d  (flags_d),
        .wr_acc   (wr_acc),
        .wr_store (wr_store),
        .wr_flags (wr_flags)
    );

    for (genvar i = 0; i < NACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i] <= '0;
            end else if (op_valid && wr_acc && (SEL_W'(acc_sel) == SEL_W'(i))) begin
                acc_q[i] <= result;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            store_q <= '0;
        end else if (op_valid) begin
            if (wr_flags) flags_q <= flags_d;
            if (wr_store) store_q <= result;
        end
    end

    assign acc_a      = acc_q[0];
    assign acc_b      = acc_q[1];
    assign store_data = store_q;
    assign flags      = flags_q;

endmodule

// File: rtl/acc_flag_unit_chk.sv
module acc_flag_unit_chk #(
    parameter int W  = 8,
    parameter int OW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [OW-1:0] opcode,
    input logic [W-1:0]  operand,
    input logic [W-1:0]  acc_a,
    input logic [W-1:0]  acc_b,
    input logic [W-1:0]  store_data,
    input logic [3:0]    flags
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_a == '0 && acc_b == '0 && store_data == '0 && flags == 4'b0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(store_data) && $stable(flags)));

    // R10
    undef_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode[OW-1:OW-2] == 2'b11) |=>
        ($stable(acc_a) && $stable(acc_b) && $stable(store_data) && $stable(flags)));

    // R3
    load_a_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == OW'(0)) |=>
        (acc_a == $past(operand) && !flags[1] && flags[0] == $past(flags[0])));

    // R2
    load_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode[OW-1:1] == '0) |=>
        (flags[2] == ($past(operand) == '0) && flags[3] == $past(operand[W-1])));

    // R7
    cmp_keep_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode[OW-1:1] == (OW-1)'(4)) |=> ($stable(acc_a) && $stable(acc_b)));

    // R11
    a_op_keeps_b_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !opcode[0]) |=> $stable(acc_b));

endmodule

bind acc_flag_unit acc_flag_unit_chk #(.W(W), .OW(OW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .operand    (operand),
    .acc_a      (acc_a),
    .acc_b      (acc_b),
    .store_data (store_data),
    .flags      (flags)
);

// File: tb/acc_flag_unit_bench.sv
module acc_flag_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] opcode = 4'h0;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc_a, acc_b, store_data;
    logic [3:0] flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    acc_flag_unit u_acc_flag_unit (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .opcode     (opcode),
        .operand    (operand),
        .acc_a      (acc_a),
        .acc_b      (acc_b),
        .store_data (store_data),
        .flags      (flags)
    );

    // {opcode, operand, exp acc_a, exp acc_b, exp store_data, exp flags NZVC}
    localparam int NV = 20;
    localparam logic [39:0] VEC [NV] = '{
        {4'h0, 8'h20, 8'h20, 8'h00, 8'h00, 4'b0000}, // R3 load A
        {4'h6, 8'h81, 8'h9F, 8'h00, 8'h00, 4'b1011}, // R6 32-129
        {4'h1, 8'h00, 8'h9F, 8'h00, 8'h00, 4'b0101}, // R3 load B zero, C kept
        {4'h0, 8'h7F, 8'h7F, 8'h00, 8'h00, 4'b0001}, // R3 C kept
        {4'h4, 8'h01, 8'h80, 8'h00, 8'h00, 4'b1010}, // R5 signed overflow
        {4'h2, 8'h55, 8'h80, 8'h00, 8'h80, 4'b1000}, // R4 store A
        {4'hB, 8'h33, 8'h80, 8'h00, 8'h80, 4'b0100}, // R8 test B zero
        {4'h8, 8'h80, 8'h80, 8'h00, 8'h80, 4'b0100}, // R7 compare equal
        {4'h5, 8'hFF, 8'h80, 8'hFF, 8'h80, 4'b1000}, // R5 add B
        {4'h5, 8'h01, 8'h80, 8'h00, 8'h80, 4'b0101}, // R5 unsigned carry
        {4'h1, 8'h80, 8'h80, 8'h80, 8'h80, 4'b1001}, // R3 C kept at 1
        {4'h7, 8'h01, 8'h80, 8'h7F, 8'h80, 4'b0010}, // R6 signed overflow
        {4'h8, 8'h01, 8'h80, 8'h7F, 8'h80, 4'b0010}, // R7 compare
        {4'hC, 8'hFF, 8'h80, 8'h7F, 8'h80, 4'b0010}, // R10 undefined
        {4'hF, 8'h00, 8'h80, 8'h7F, 8'h80, 4'b0010}, // R10 undefined
        {4'h3, 8'h00, 8'h80, 8'h7F, 8'h7F, 4'b0000}, // R4 store B
        {4'hA, 8'h00, 8'h80, 8'h7F, 8'h7F, 4'b1000}, // R8 test A
        {4'h9, 8'hFF, 8'h80, 8'h7F, 8'h7F, 4'b1011}, // R7 compare borrow
        {4'h4, 8'h80, 8'h00, 8'h7F, 8'h7F, 4'b0111}, // R5 wrap to zero
        {4'hA, 8'h00, 8'h00, 8'h7F, 8'h7F, 4'b0100}  // R8 test zero
    };

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {acc_a, acc_b, store_data, flags}, 28'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            op_valid = 1'b1;
            opcode   = VEC[i][39:36];
            operand  = VEC[i][35:28];
            @(negedge clk);
            check($sformatf("R2/R11 vec%0d", i), {acc_a, acc_b, store_data, flags}, VEC[i][27:0]);
        end

        // R9: idle with an operation pattern that would change state
        op_valid = 1'b0;
        opcode   = 4'h1;
        operand  = 8'hAA;
        repeat (2) @(negedge clk);
        check("R9", {acc_a, acc_b, store_data, flags}, {8'h00, 8'h7F, 8'h7F, 4'b0100});

        // R6 again on B: 0x7F - 0x7F = 0, flags 0100
        op_valid = 1'b1;
        opcode   = 4'h7;
        operand  = 8'h7F;
        @(negedge clk);
        check("R6", {acc_a, acc_b, store_data, flags}, {8'h00, 8'h00, 8'h7F, 4'b0100});

        // R1 reset mid-run
        op_valid = 1'b0;
        opcode   = 4'h0;
        operand  = 8'h11;
        op_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", {acc_a, acc_b, store_data, flags}, 28'h0);
        rst = 1'b0;
        op_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule